// File: doc/BRIEF.md
# Target and Period Comparator Alarm

A bank of three comparators watches two free-running count values supplied on ports. Each comparator chooses one of the two counts. In one-shot mode it raises a single alarm when that count reaches a 52-bit trigger point. In repeating mode it raises an alarm at a fixed spacing, measured from the count seen when the mode turns on. Each alarm appears as a one-cycle event pulse. The same pulse also latches a per-comparator pending bit, which an enable mask gates onto the interrupt outputs.

Trigger and spacing values are written through a narrow write port into per-comparator staging registers. They only reach the compare logic when that comparator's load strobe is pulsed. Software can therefore stage a full 52-bit value across two writes without the comparator ever seeing half of it. The counters themselves, and the routing of interrupts to processors, live outside the block.

Top module: `tgt_period_alarm`

## Requirements
- R1: A comparator whose enable input is low produces no event pulse. It keeps its armed one-shot state, so a trigger point that was passed while it was disabled fires once it is enabled again.
- R2: The unit-select input of a comparator picks the count it compares: 0 takes `cnt0_i`, 1 takes `cnt1_i`.
- R3: A write with `wr_en_i` high updates the staging registers of comparator `wr_idx_i` (an index of 3 hits none). Field code 0 puts `wr_data_i[31:0]` into trigger bits 31:0. Code 1 puts `wr_data_i[19:0]` into trigger bits 51:32. Code 2 puts `wr_data_i[25:0]` into the 26-bit spacing and discards bits 31:26. Code 3 changes nothing.
- R4: In one-shot mode (mode input 0), after a load the comparator raises its event pulse one cycle after the first cycle in which it is enabled and its selected count is at or above the active trigger point. It then stays silent until the next load.
- R5: In repeating mode (mode input 1), the first cycle in which the mode is seen high after being low records the selected count plus the active spacing as the next trigger, and raises no alarm. Each later cycle whose count is at or above that trigger raises the pulse one cycle later and adds the spacing again. Dropping the mode to 0 stops repeating alarms.
- R6: A load strobe copies the staging trigger and spacing as they stood before that clock edge into the active registers. A write in the same cycle reaches only the staging registers.
- R7: The pending bit of a comparator is set in the cycle after its event pulse. It stays set until a 1 is written to its clear input. A set and a clear in the same cycle leave it set.
- R8: Each interrupt output equals the pending bit AND its enable-mask bit. The mask has no effect on the pending bit.
- R9: While the reset synchroniser holds reset and right after it, all event, pending and interrupt outputs are 0, all staging and active values are 0, and no one-shot trigger is armed.
- R10: A one-shot event pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchroniser |
| cnt0_i | input | 52 | Count value of unit 0 |
| cnt1_i | input | 52 | Count value of unit 1 |
| cmp_en_i | input | 3 | Per-comparator enable |
| unit_sel_i | input | 3 | Per-comparator count select (0: unit 0, 1: unit 1) |
| mode_i | input | 3 | Per-comparator mode (0: one-shot, 1: repeating) |
| load_i | input | 3 | Per-comparator load strobe, staging to active |
| wr_en_i | input | 1 | Staging write strobe |
| wr_idx_i | input | 2 | Comparator addressed by the write |
| wr_field_i | input | 2 | Field code of the write (see R3) |
| wr_data_i | input | 32 | Write data |
| int_ena_i | input | 3 | Interrupt enable mask |
| int_clr_i | input | 3 | Write-one-to-clear for the pending bits |
| alarm_evt_o | output | 3 | One-cycle alarm event pulses |
| int_raw_o | output | 3 | Pending (raw) interrupt bits |
| int_o | output | 3 | Masked interrupt outputs |

## Verification
Two pairs of actions can land in the same cycle. The first is a staging write and a load strobe for the same comparator. The bench writes the upper trigger word together with the load and expects the comparator to fire at once on the stale upper word of zero. The second is an event pulse and a clear of the pending bit. The bench waits until it sees a pulse on the outputs, drives the clear in that cycle, and expects the pending bit still set afterwards. The random phase produces both collisions many more times, and a cycle-level reference model in the bench judges each one.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;

  localparam int unsigned DEF_NUM_CMP = 3;
  localparam int unsigned DEF_CNT_W   = 52;
  localparam int unsigned DEF_PER_W   = 26;
  localparam int unsigned DEF_DATA_W  = 32;

  // Field code carried by a staging write.
  typedef enum logic [1:0] {
    FLD_TGT_LO = 2'd0,
    FLD_TGT_HI = 2'd1,
    FLD_PERIOD = 2'd2,
    FLD_NONE   = 2'd3
  } wr_field_e;

endpackage

// File: rtl/alarm_shadow.sv
// Staging and active copies of one comparator's trigger and spacing.
module alarm_shadow
  import alarm_cmp_pkg::*;
#(
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned PER_W  = DEF_PER_W,
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        field_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              load_i,
  output logic [CNT_W-1:0]  act_tgt_o,
  output logic [PER_W-1:0]  act_per_o
);

  localparam int unsigned HI_W = CNT_W - DATA_W;

  logic [CNT_W-1:0] shd_tgt_q, shd_tgt_n;
  logic [PER_W-1:0] shd_per_q, shd_per_n;
  logic [CNT_W-1:0] act_tgt_q;
  logic [PER_W-1:0] act_per_q;
  wr_field_e        fld;

  assign fld = wr_field_e'(field_i);

  always_comb begin
    shd_tgt_n = shd_tgt_q;
    shd_per_n = shd_per_q;
    if (wr_i) begin
      case (fld)
        FLD_TGT_LO: shd_tgt_n[DATA_W-1:0]     = data_i;
        FLD_TGT_HI: shd_tgt_n[CNT_W-1:DATA_W] = data_i[HI_W-1:0];
        FLD_PERIOD: shd_per_n                 = data_i[PER_W-1:0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_tgt_q <= '0;
      shd_per_q <= '0;
    end else if (wr_i) begin
      shd_tgt_q <= shd_tgt_n;
      shd_per_q <= shd_per_n;
    end
  end

  // Active copy takes the staging value from before this edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_tgt_q <= '0;
      act_per_q <= '0;
    end else if (load_i) begin
      act_tgt_q <= shd_tgt_q;
      act_per_q <= shd_per_q;
    end
  end

  assign act_tgt_o = act_tgt_q;
  assign act_per_o = act_per_q;

  // R6: load moves the pre-edge staging values into the active copy
  a_r6_load_copies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (act_tgt_o == $past(shd_tgt_q)) && (act_per_o == $past(shd_per_q)));

endmodule

// File: rtl/alarm_cmp.sv
// Compare engine of one comparator: one-shot and repeating operation.
module alarm_cmp
  import alarm_cmp_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W,
  parameter int unsigned PER_W = DEF_PER_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             usel_i,
  input  logic             mode_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt0_i,
  input  logic [CNT_W-1:0] cnt1_i,
  input  logic [CNT_W-1:0] act_tgt_i,
  input  logic [PER_W-1:0] act_per_i,
  output logic             alarm_o
);

  localparam int unsigned PAD_W = CNT_W - PER_W;

  logic [CNT_W-1:0] cnt_sel;
  logic [CNT_W-1:0] per_ext;
  logic             mode_q;
  logic             armed_q, armed_n;
  logic [CNT_W-1:0] nxt_q, nxt_n;
  logic             nxt_en;
  logic             alarm_q;
  logic             rise, per_run, hit_tgt, hit_per, fire;

  assign cnt_sel = usel_i ? cnt1_i : cnt0_i;
  assign per_ext = {{PAD_W{1'b0}}, act_per_i};

  always_comb begin
    rise    = mode_i & ~mode_q;
    per_run = mode_i & mode_q;
    hit_tgt = armed_q & (cnt_sel >= act_tgt_i);
    hit_per = per_run & (cnt_sel >= nxt_q);
    fire    = en_i & (mode_i ? hit_per : hit_tgt);

    if (load_i)               armed_n = 1'b1;
    else if (fire && !mode_i) armed_n = 1'b0;
    else                      armed_n = armed_q;

    nxt_en = rise | (fire & mode_i);
    if (rise) nxt_n = cnt_sel + per_ext;
    else      nxt_n = nxt_q + per_ext;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= 1'b0;
      armed_q <= 1'b0;
      alarm_q <= 1'b0;
    end else begin
      mode_q  <= mode_i;
      armed_q <= armed_n;
      alarm_q <= fire;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     nxt_q <= '0;
    else if (nxt_en) nxt_q <= nxt_n;
  end

  assign alarm_o = alarm_q;

  // R1: a disabled comparator raises nothing
  a_r1_disabled_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !alarm_o);

  // R5: the cycle that turns repeating mode on never fires
  a_r5_rise_no_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !mode_q) |=> !alarm_o);

  // R10: a one-shot pulse is not followed by another without a new load
  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o && !$past(mode_i) && !$past(load_i) && !mode_i) |=> !alarm_o);

endmodule

// File: rtl/alarm_irq.sv
// Pending bits with write-one-to-clear and enable mask.
module alarm_irq
  import alarm_cmp_pkg::*;
#(
  parameter int unsigned NUM_CMP = DEF_NUM_CMP
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CMP-1:0] alarm_i,
  input  logic [NUM_CMP-1:0] clr_i,
  input  logic [NUM_CMP-1:0] ena_i,
  output logic [NUM_CMP-1:0] raw_o,
  output logic [NUM_CMP-1:0] irq_o
);

  logic [NUM_CMP-1:0] raw_q, raw_n;
  logic               raw_en;

  always_comb begin
    raw_n  = (raw_q & ~clr_i) | alarm_i;
    raw_en = |(clr_i | alarm_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     raw_q <= '0;
    else if (raw_en) raw_q <= raw_n;
  end

  assign raw_o = raw_q;
  assign irq_o = raw_q & ena_i;

  // R7: every event pulse leaves its pending bit set
  a_r7_set_on_alarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_i != '0) |=> ((raw_q & $past(alarm_i)) == $past(alarm_i)));

  // R7: an uncleared pending bit holds
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((raw_q & ~clr_i) != '0) |=> ((raw_q & $past(raw_q & ~clr_i)) == $past(raw_q & ~clr_i)));

endmodule

// File: rtl/tgt_period_alarm.sv
module tgt_period_alarm
  import alarm_cmp_pkg::*;
#(
  parameter int unsigned NUM_CMP = DEF_NUM_CMP,
  parameter int unsigned CNT_W   = DEF_CNT_W,
  parameter int unsigned PER_W   = DEF_PER_W,
  parameter int unsigned DATA_W  = DEF_DATA_W,
  localparam int unsigned IDX_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP + 1) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cnt0_i,
  input  logic [CNT_W-1:0]   cnt1_i,
  input  logic [NUM_CMP-1:0] cmp_en_i,
  input  logic [NUM_CMP-1:0] unit_sel_i,
  input  logic [NUM_CMP-1:0] mode_i,
  input  logic [NUM_CMP-1:0] load_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [1:0]         wr_field_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [NUM_CMP-1:0] int_ena_i,
  input  logic [NUM_CMP-1:0] int_clr_i,
  output logic [NUM_CMP-1:0] alarm_evt_o,
  output logic [NUM_CMP-1:0] int_raw_o,
  output logic [NUM_CMP-1:0] int_o
);

  logic rst_s1, rst_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic [NUM_CMP-1:0] alarm;

  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
    logic             wr_hit;
    logic [CNT_W-1:0] act_tgt;
    logic [PER_W-1:0] act_per;

    assign wr_hit = wr_en_i && (wr_idx_i == IDX_W'(gi));

    alarm_shadow #(
      .CNT_W (CNT_W),
      .PER_W (PER_W),
      .DATA_W(DATA_W)
    ) u_shadow (
      .clk_i    (clk),
      .rst_ni   (rst_s2),
      .wr_i     (wr_hit),
      .field_i  (wr_field_i),
      .data_i   (wr_data_i),
      .load_i   (load_i[gi]),
      .act_tgt_o(act_tgt),
      .act_per_o(act_per)
    );

    alarm_cmp #(
      .CNT_W(CNT_W),
      .PER_W(PER_W)
    ) u_cmp (
      .clk_i    (clk),
      .rst_ni   (rst_s2),
      .en_i     (cmp_en_i[gi]),
      .usel_i   (unit_sel_i[gi]),
      .mode_i   (mode_i[gi]),
      .load_i   (load_i[gi]),
      .cnt0_i   (cnt0_i),
      .cnt1_i   (cnt1_i),
      .act_tgt_i(act_tgt),
      .act_per_i(act_per),
      .alarm_o  (alarm[gi])
    );
  end

  alarm_irq #(
    .NUM_CMP(NUM_CMP)
  ) u_irq (
    .clk_i  (clk),
    .rst_ni (rst_s2),
    .alarm_i(alarm),
    .clr_i  (int_clr_i),
    .ena_i  (int_ena_i),
    .raw_o  (int_raw_o),
    .irq_o  (int_o)
  );

  assign alarm_evt_o = alarm;

endmodule

// File: tb/tgt_period_alarm_tb.sv
module tgt_period_alarm_tb;

  localparam int N  = 3;
  localparam int CW = 52;
  localparam int PW = 26;
  localparam int DW = 32;
  localparam logic [CW-1:0] START0 = 52'hA_BCDE_0000_0F00;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [CW-1:0] cnt0 = START0;
  logic [CW-1:0] cnt1 = START0 - 52'd300;
  logic [N-1:0]  en, usel, mode, load, clr, ena;
  logic          wr_en;
  logic [1:0]    wr_idx, wr_field;
  logic [DW-1:0] wr_data;
  logic [N-1:0]  evt_o, raw_o, int_o;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string evt_req = "R9";

  tgt_period_alarm u_dut (
    .clk(clk), .rst_n(rst_n), .cnt0_i(cnt0), .cnt1_i(cnt1),
    .cmp_en_i(en), .unit_sel_i(usel), .mode_i(mode), .load_i(load),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_field_i(wr_field), .wr_data_i(wr_data),
    .int_ena_i(ena), .int_clr_i(clr),
    .alarm_evt_o(evt_o), .int_raw_o(raw_o), .int_o(int_o)
  );

  always @(negedge clk) begin
    cnt0 <= cnt0 + 52'd1;
    cnt1 <= cnt1 + 52'd2;
  end

  // Reference model built from the requirements
  logic [CW-1:0] m_st[N], m_at[N], m_nxt[N];
  logic [PW-1:0] m_sp[N], m_ap[N];
  logic [N-1:0]  m_arm, m_mq, m_evt, m_raw;

  function automatic logic [CW-1:0] sel_cnt(input int i);
    return usel[i] ? cnt1 : cnt0;
  endfunction

  function automatic bit want_fire(input int i);
    logic [CW-1:0] s;
    s = sel_cnt(i);
    if (!en[i]) return 1'b0;
    if (mode[i]) return m_mq[i] && (s >= m_nxt[i]);
    return m_arm[i] && (s >= m_at[i]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_st[i] = '0; m_at[i] = '0; m_nxt[i] = '0; m_sp[i] = '0; m_ap[i] = '0;
      end
      m_arm = '0; m_mq = '0; m_evt = '0; m_raw = '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        bit f;
        f = want_fire(i);
        m_raw[i] = (m_raw[i] && !clr[i]) || m_evt[i];
        m_evt[i] = f;
        if (mode[i] && !m_mq[i]) m_nxt[i] = sel_cnt(i) + {26'd0, m_ap[i]};
        else if (f && mode[i])   m_nxt[i] = m_nxt[i] + {26'd0, m_ap[i]};
        if (load[i])              m_arm[i] = 1'b1;
        else if (f && !mode[i])   m_arm[i] = 1'b0;
        if (load[i]) begin m_at[i] = m_st[i]; m_ap[i] = m_sp[i]; end
        m_mq[i] = mode[i];
        if (wr_en && wr_idx == 2'(i)) begin
          case (wr_field)
            2'd0: m_st[i][31:0]  = wr_data;
            2'd1: m_st[i][51:32] = wr_data[19:0];
            2'd2: m_sp[i]        = wr_data[25:0];
            default: ;
          endcase
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic auto_check();
    for (int i = 0; i < N; i++) begin
      string r;
      r = (evt_req != "") ? evt_req : (mode[i] ? "R5" : "R4");
      chk(r, $sformatf("evt[%0d]", i), 64'(evt_o[i]), 64'(m_evt[i]));
      chk("R7", $sformatf("raw[%0d]", i), 64'(raw_o[i]), 64'(m_raw[i]));
      chk("R8", $sformatf("int[%0d]", i), 64'(int_o[i]), 64'(m_raw[i] & ena[i]));
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    auto_check();
    #1;
    load = '0; clr = '0; wr_en = 1'b0;
  endtask

  task automatic wr(input int idx, input int fld, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_idx = 2'(idx); wr_field = 2'(fld); wr_data = d;
    step();
  endtask

  task automatic run_count(input int i, input int n, output int pulses, output int maxrun);
    int run;
    pulses = 0; maxrun = 0; run = 0;
    for (int k = 0; k < n; k++) begin
      step();
      if (evt_o[i]) begin
        run++;
        if (run == 1) pulses++;
        if (run > maxrun) maxrun = run;
      end else run = 0;
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] tv;
    int p, mr;
    bit hit;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    en = '0; usel = '0; mode = '0; load = '0; clr = '0; ena = '0;
    wr_en = 1'b0; wr_idx = '0; wr_field = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R9", "evt in reset", 64'(evt_o), 64'd0);
    chk("R9", "raw in reset", 64'(raw_o), 64'd0);
    #1 rst_n = 1'b1;
    repeat (4) step();
    chk("R9", "int after reset", 64'(int_o), 64'd0);

    // R6 and R3: upper word written in the same cycle as the load
    en[0] = 1'b1; ena = '1; evt_req = "R6";
    tv = cnt0 + 52'd30;
    wr(0, 0, tv[31:0]);
    wr_en = 1'b1; wr_idx = 2'd0; wr_field = 2'd1; wr_data = 32'(tv[51:32]); load[0] = 1'b1;
    step();
    chk("R6", "no pulse right after load", 64'(evt_o[0]), 64'd0);
    step();
    chk("R6", "stale upper word fires", 64'(evt_o[0]), 64'd1);
    step();
    chk("R7", "pending after pulse", 64'(raw_o[0]), 64'd1);
    clr[0] = 1'b1; step();
    chk("R7", "cleared", 64'(raw_o[0]), 64'd0);

    // R3: field code 3 changes nothing; then R4 and R10 on the full target
    wr(0, 3, 32'h0);
    load[0] = 1'b1; step();
    evt_req = "R3";
    run_count(0, 10, p, mr);
    chk("R3", "field 3 left trigger intact", 64'(p), 64'd0);
    evt_req = "R4";
    run_count(0, 30, p, mr);
    chk("R4", "one-shot pulse count", 64'(p), 64'd1);
    chk("R10", "pulse width", 64'(mr), 64'd1);

    // R1: disabled comparator stays quiet, fires once enabled
    evt_req = "R1";
    tv = cnt0 + 52'd10;
    wr(1, 0, tv[31:0]);
    wr(1, 1, 32'(tv[51:32]));
    load[1] = 1'b1; step();
    run_count(1, 30, p, mr);
    chk("R1", "disabled pulses", 64'(p), 64'd0);
    en[1] = 1'b1;
    run_count(1, 5, p, mr);
    chk("R1", "pulse after enable", 64'(p), 64'd1);

    // R2: comparator 2 follows unit 1
    evt_req = "R2";
    usel[2] = 1'b1; en[2] = 1'b1;
    tv = cnt1 + 52'd40;
    wr(2, 0, tv[31:0]);
    wr(2, 1, 32'(tv[51:32]));
    load[2] = 1'b1; step();
    run_count(2, 5, p, mr);
    chk("R2", "no early pulse from unit 0", 64'(p), 64'd0);
    run_count(2, 35, p, mr);
    chk("R2", "pulse from unit 1", 64'(p), 64'd1);

    // R5: repeating mode, spacing 10 with junk in discarded bits
    evt_req = "R5";
    tv = cnt0 + 52'd10000;
    wr(0, 0, tv[31:0]);
    wr(0, 1, 32'(tv[51:32]));
    wr(0, 2, 32'hFC00_000A);
    load[0] = 1'b1; step();
    mode[0] = 1'b1;
    run_count(0, 55, p, mr);
    chk("R5", "repeating pulses in 55 cycles", 64'(p), 64'd5);
    mode[0] = 1'b0;
    run_count(0, 20, p, mr);
    chk("R5", "stopped after mode drop", 64'(p), 64'd0);

    // R7: clear and pulse in the same cycle
    evt_req = "R7";
    clr[1] = 1'b1; step();
    chk("R7", "pending cleared", 64'(raw_o[1]), 64'd0);
    tv = cnt0 + 52'd6;
    wr(1, 0, tv[31:0]);
    wr(1, 1, 32'(tv[51:32]));
    load[1] = 1'b1; step();
    hit = 1'b0;
    for (int k = 0; k < 20 && !hit; k++) begin
      if (evt_o[1]) begin
        clr[1] = 1'b1;
        step();
        chk("R7", "set wins over clear", 64'(raw_o[1]), 64'd1);
        hit = 1'b1;
      end else step();
    end
    chk("R7", "collision provoked", 64'(hit), 64'd1);
    clr[1] = 1'b1; step();
    chk("R7", "clear afterwards", 64'(raw_o[1]), 64'd0);

    // R8: mask gates output only
    ena = '0; step();
    chk("R8", "masked output", 64'(int_o), 64'd0);
    chk("R8", "pending kept under mask", 64'(raw_o[0]), 64'd1);

    // Random phase
    evt_req = "";
    ena = '1;
    for (int c = 0; c < 4000; c++) begin
      int r, idx;
      logic [CW-1:0] base;
      r = $urandom_range(0, 99);
      idx = $urandom_range(0, 3);
      base = ((idx < 3 && usel[idx]) ? cnt1 : cnt0) + 52'($urandom_range(0, 120));
      if (r < 6)       begin wr_en = 1'b1; wr_idx = 2'(idx); wr_field = 2'd0; wr_data = base[31:0]; end
      else if (r < 10) begin wr_en = 1'b1; wr_idx = 2'(idx); wr_field = 2'd1; wr_data = 32'(base[51:32]); end
      else if (r < 13) begin wr_en = 1'b1; wr_idx = 2'(idx); wr_field = 2'd2;
                             wr_data = ($urandom & 32'hFC00_0000) | 32'($urandom_range(2, 40)); end
      else if (r < 15) begin wr_en = 1'b1; wr_idx = 2'(idx); wr_field = 2'd3; wr_data = $urandom; end
      for (int i = 0; i < N; i++) begin
        if ($urandom_range(0, 99) < 4)   load[i] = 1'b1;
        if ($urandom_range(0, 99) < 6)   clr[i]  = 1'b1;
        if ($urandom_range(0, 199) < 4)  en[i]   = ~en[i];
        if ($urandom_range(0, 199) < 3)  mode[i] = ~mode[i];
        if ($urandom_range(0, 199) < 2)  usel[i] = ~usel[i];
        if ($urandom_range(0, 99) < 3)   ena[i]  = ~ena[i];
      end
      step();
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule